// File: doc/BRIEF.md
# Standstill Current Reduction Sequencer

This block sets the current scale that a stepper motor driver applies to its coils. While the motor is in motion, it outputs the run current code. When motion stops, it keeps the run current until an external standstill wait period reports that it has expired. It then reduces the current towards the hold current. The reduction is either a single jump or a staircase that lowers the code by one step per programmable period.

A 32-bit configuration word carries the run code, the hold code and a 4-bit delay code. The block captures this word on every clock. The step period equals the delay code multiplied by `2^STEP_SHIFT` clocks. `STEP_SHIFT` defaults to 18, and a testbench can make it smaller to keep delays short. The motion ramp generator and the analog current regulation are outside this block.

Top module: `hold_step_seq`

## Requirements
- R1: The block captures the configuration word on every clock edge. Hold code is bits 4:0, run code is bits 12:8 and delay code is bits 19:16; all other bits have no effect. An output code n stands for a scale of (n+1)/32, and the block outputs the code itself. A change to the configuration reaches the output two edges after it is applied.
- R2: After reset the captured configuration is all zero, the block is in the run phase and the output is 0.
- R3: On each edge where `moving_i` is sampled high, the output becomes the captured run code.
- R4: After motion ends, the output stays at the run code until an edge samples `wait_done_i` high.
- R5: If the delay code is 0 when the wait expires, the output becomes the hold code on that same edge.
- R6: If the delay code is nonzero, the output falls by exactly one code every delay×2^STEP_SHIFT clocks, and the first step comes that long after the wait expires. The reduction ends at the hold code.
- R7: If the hold code is equal to or above the present scale when the wait expires, or at any point during the staircase, the output jumps straight to the hold code.
- R8: If motion restarts during a staircase, the staircase is aborted and the output returns to the run code on the next edge.
- R9: `wait_done_i` has no effect while the motor is moving, during the staircase, or after the hold code has been reached.
- R10: Once the hold code has been reached, the output follows any later change of the hold code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_i | input | 32 | Configuration word (hold, run and delay codes) |
| moving_i | input | 1 | Motion active |
| wait_done_i | input | 1 | Standstill wait period has expired |
| cur_scale_o | output | 5 | Current scale code |

## Verification
The assertions check four things on every cycle:
- a sampled motion flag always yields the run code on the next edge;
- during the staircase the scale only holds, drops by one, or jumps to the hold code;
- a zero delay code or a hold code at or above the present scale leads directly to the hold code;
- the hold phase tracks the hold field.

Only the bench scenarios can show the following:
- the exact spacing of steps in clocks;
- the two-edge latency of configuration changes;
- that wait-expired pulses are ignored while moving and after power-down;
- that unused configuration bits have no effect.

The bench covers these by comparing the output against a behavioural model on every clock.

// File: rtl/hs_pkg.sv
package hs_pkg;
  localparam int unsigned CODE_W  = 5;
  localparam int unsigned DLY_W   = 4;
  localparam int unsigned CFG_W   = 32;
  localparam int unsigned HOLD_LSB = 0;
  localparam int unsigned RUN_LSB  = 8;
  localparam int unsigned DLY_LSB  = 16;

  typedef enum logic [1:0] {
    PH_RUN  = 2'd0,
    PH_DOWN = 2'd1,
    PH_HOLD = 2'd2
  } hs_phase_e;

  typedef struct packed {
    logic [DLY_W-1:0]  dly;
    logic [CODE_W-1:0] run;
    logic [CODE_W-1:0] hold;
  } hs_cfg_t;

  function automatic hs_cfg_t hs_unpack(input logic [CFG_W-1:0] w);
    hs_cfg_t c;
    c.hold = w[HOLD_LSB +: CODE_W];
    c.run  = w[RUN_LSB  +: CODE_W];
    c.dly  = w[DLY_LSB  +: DLY_W];
    return c;
  endfunction
endpackage

// File: rtl/hs_cfg_reg.sv
module hs_cfg_reg
  import hs_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] cfg_i,
  output hs_cfg_t          cfg_o
);
  hs_cfg_t cfg_q;
  logic    unused_bits;

  // fields outside hold/run/delay carry no function
  assign unused_bits = ^{cfg_i[CFG_W-1:DLY_LSB+DLY_W],
                         cfg_i[DLY_LSB-1:RUN_LSB+CODE_W],
                         cfg_i[RUN_LSB-1:HOLD_LSB+CODE_W]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cfg_q <= '0;
    else         cfg_q <= hs_unpack(cfg_i);
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/hs_step_timer.sv
module hs_step_timer #(
  parameter int unsigned STEP_SHIFT = 18,
  parameter int unsigned DLY_W      = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             tick_o
);
  localparam int unsigned CNT_W = STEP_SHIFT + DLY_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   period;

  assign cnt_inc = {1'b0, cnt_q} + 1'b1;
  assign period  = {1'b0, dly_i, {STEP_SHIFT{1'b0}}};
  assign tick_o  = run_i && (dly_i != '0) && (cnt_inc >= period);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_inc[CNT_W-1:0];
  end

  // R6: a step never fires before a full period has elapsed
  a_r6_tick_after_period: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && !tick_o && $past(!run_i)) |=> !tick_o || (dly_i <= 1 && STEP_SHIFT <= 1));
endmodule

// File: rtl/hs_scale_fsm.sv
module hs_scale_fsm
  import hs_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  hs_cfg_t           cfg_i,
  input  logic              moving_i,
  input  logic              wait_done_i,
  input  logic              tick_i,
  output hs_phase_e         phase_o,
  output logic [CODE_W-1:0] scale_o
);
  hs_phase_e         phase_q, phase_d;
  logic [CODE_W-1:0] scale_q, scale_d;
  logic [CODE_W-1:0] scale_dec;

  assign scale_dec = scale_q - 1'b1;

  always_comb begin
    phase_d = phase_q;
    scale_d = scale_q;
    if (moving_i) begin
      phase_d = PH_RUN;
      scale_d = cfg_i.run;
    end else begin
      unique case (phase_q)
        PH_RUN: begin
          scale_d = cfg_i.run;
          if (wait_done_i) begin
            if (cfg_i.dly == '0 || cfg_i.hold >= cfg_i.run) begin
              phase_d = PH_HOLD;
              scale_d = cfg_i.hold;
            end else begin
              phase_d = PH_DOWN;
            end
          end
        end
        PH_DOWN: begin
          if (cfg_i.dly == '0 || cfg_i.hold >= scale_q) begin
            phase_d = PH_HOLD;
            scale_d = cfg_i.hold;
          end else if (tick_i) begin
            scale_d = scale_dec;
            if (scale_dec == cfg_i.hold) phase_d = PH_HOLD;
          end
        end
        PH_HOLD: scale_d = cfg_i.hold;
        default: begin
          phase_d = PH_RUN;
          scale_d = cfg_i.run;
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_RUN;
      scale_q <= '0;
    end else begin
      phase_q <= phase_d;
      scale_q <= scale_d;
    end
  end

  assign phase_o = phase_q;
  assign scale_o = scale_q;

  // R6: staircase moves by at most one code, or lands on hold
  a_r6_step_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DOWN && !moving_i) |=>
      (scale_q == $past(scale_q)) || (scale_q == $past(scale_q) - 1'b1) ||
      (scale_q == $past(cfg_i.hold)));

  // R5: zero delay goes straight to hold
  a_r5_zero_delay_direct: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_RUN && !moving_i && wait_done_i && cfg_i.dly == '0) |=>
      (scale_q == $past(cfg_i.hold)) && (phase_q == PH_HOLD));

  // R7: hold at or above present scale jumps
  a_r7_jump_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_DOWN && !moving_i && cfg_i.hold >= scale_q) |=>
      scale_q == $past(cfg_i.hold));

  // R10: hold phase tracks hold field
  a_r10_hold_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_HOLD && !moving_i) |=> (scale_q == $past(cfg_i.hold)) && (phase_q == PH_HOLD));
endmodule

// File: rtl/hold_step_seq.sv
module hold_step_seq
  import hs_pkg::*;
#(
  parameter int unsigned STEP_SHIFT = 18
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       cfg_i,
  input  logic              moving_i,
  input  logic              wait_done_i,
  output logic [4:0]        cur_scale_o
);
  hs_cfg_t   cfg_w;
  hs_phase_e phase_w;
  logic      tick_w;

  hs_cfg_reg u_cfg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cfg_i  (cfg_i),
    .cfg_o  (cfg_w)
  );

  hs_step_timer #(
    .STEP_SHIFT (STEP_SHIFT),
    .DLY_W      (DLY_W)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (phase_w == PH_DOWN),
    .dly_i  (cfg_w.dly),
    .tick_o (tick_w)
  );

  hs_scale_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cfg_i       (cfg_w),
    .moving_i    (moving_i),
    .wait_done_i (wait_done_i),
    .tick_i      (tick_w),
    .phase_o     (phase_w),
    .scale_o     (cur_scale_o)
  );

  // R3 / R8: sampled motion yields the run code next edge
  a_r8_run_on_motion: assert property (@(posedge clk_i) disable iff (!rst_ni)
    moving_i |=> cur_scale_o == $past(cfg_w.run));
endmodule

// File: tb/hold_step_seq_tb.sv
module hold_step_seq_tb;
  localparam int SH  = 2;
  localparam int WDG = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg = '0;
  logic        moving = 1'b0;
  logic        wait_done = 1'b0;
  logic [4:0]  scale;

  int    n_tests = 0;
  int    n_fail  = 0;
  string cur_req = "R2";
  bit    done = 1'b0;

  always #5 clk = ~clk;

  hold_step_seq #(.STEP_SHIFT(SH)) u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_i       (cfg),
    .moving_i    (moving),
    .wait_done_i (wait_done),
    .cur_scale_o (scale)
  );

  // behavioural reference: phase 0 run/wait, 1 staircase, 2 hold
  int m_cfg_run, m_cfg_hold, m_cfg_dly;
  int m_phase, m_timer, m_scale;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cfg_run = 0; m_cfg_hold = 0; m_cfg_dly = 0;
      m_phase = 0; m_timer = 0; m_scale = 0;
    end else begin
      if (moving) begin
        m_phase = 0; m_scale = m_cfg_run; m_timer = 0;
      end else if (m_phase == 0) begin
        m_scale = m_cfg_run;
        if (wait_done) begin
          if (m_cfg_dly == 0 || m_cfg_hold >= m_cfg_run) begin
            m_phase = 2; m_scale = m_cfg_hold;
          end else begin
            m_phase = 1; m_timer = 0;
          end
        end
      end else if (m_phase == 1) begin
        if (m_cfg_dly == 0 || m_cfg_hold >= m_scale) begin
          m_phase = 2; m_scale = m_cfg_hold; m_timer = 0;
        end else if (m_timer + 1 >= m_cfg_dly * (1 << SH)) begin
          m_scale = m_scale - 1; m_timer = 0;
          if (m_scale == m_cfg_hold) m_phase = 2;
        end else begin
          m_timer = m_timer + 1;
        end
      end else begin
        m_scale = m_cfg_hold;
      end
      m_cfg_hold = int'(cfg[4:0]);
      m_cfg_run  = int'(cfg[12:8]);
      m_cfg_dly  = int'(cfg[19:16]);
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_tests++;
      if (int'(scale) != m_scale) begin
        n_fail++;
        $display("FAIL %s model compare: actual %0d expected %0d at %0t", cur_req, scale, m_scale, $time);
      end
    end
  end

  task automatic chk(input string req, input int exp);
    n_tests++;
    if (int'(scale) != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, scale, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] mk(input int run, input int hold, input int dly);
    return {12'h000, 4'(dly), 3'b000, 5'(run), 3'b000, 5'(hold)};
  endfunction

  initial begin
    step(2);
    chk("R2", 0);
    rst_n = 1'b1;
    step(2);
    chk("R2", 0);

    // R3, R4, R5: zero delay
    cur_req = "R3";
    cfg = mk(20, 5, 0); moving = 1'b1;
    step(3); chk("R3", 20);
    cur_req = "R4";
    moving = 1'b0;
    step(5); chk("R4", 20);
    cur_req = "R5";
    wait_done = 1'b1; step(1); wait_done = 1'b0;
    chk("R5", 5);
    step(3); chk("R5", 5);

    // R9: wait_done while holding and while moving
    cur_req = "R9";
    wait_done = 1'b1; step(3); chk("R9", 5);
    moving = 1'b1; step(2); chk("R9", 20);
    wait_done = 1'b0; moving = 1'b0;

    // R6: staircase 10 -> 6, period 2*4 = 8
    cur_req = "R6";
    cfg = mk(10, 6, 2); moving = 1'b1; step(3);
    moving = 1'b0; step(2);
    wait_done = 1'b1; step(1); wait_done = 1'b0;
    step(7); chk("R6", 10);
    step(1); chk("R6", 9);
    wait_done = 1'b1; step(8); chk("R9", 8);
    wait_done = 1'b0;
    step(8); chk("R6", 7);
    step(8); chk("R6", 6);
    step(20); chk("R6", 6);

    // R10: hold code change tracked
    cur_req = "R10";
    cfg = mk(10, 3, 2); step(2); chk("R10", 3);

    // R8: abort mid-staircase
    cur_req = "R8";
    cfg = mk(12, 2, 1); moving = 1'b1; step(3);
    moving = 1'b0; wait_done = 1'b1; step(1); wait_done = 1'b0;
    step(9); chk("R8", 10);
    moving = 1'b1; step(1); chk("R8", 12);
    moving = 1'b0; step(2); chk("R8", 12);

    // R7: hold above run, then hold raised during staircase
    cur_req = "R7";
    cfg = mk(3, 9, 3); moving = 1'b1; step(3); moving = 1'b0;
    wait_done = 1'b1; step(1); wait_done = 1'b0;
    chk("R7", 9);
    cfg = mk(15, 4, 3); moving = 1'b1; step(3); moving = 1'b0;
    wait_done = 1'b1; step(1); wait_done = 1'b0;
    step(14); chk("R7", 14);
    cfg = mk(15, 20, 3); step(2); chk("R7", 20);

    // R1: junk in unused bits has no effect
    cur_req = "R1";
    cfg = mk(18, 7, 0) | 32'hFFF0_E0E0; moving = 1'b1; step(3);
    chk("R1", 18);
    moving = 1'b0; wait_done = 1'b1; step(1); wait_done = 1'b0;
    chk("R1", 7);
    step(4);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (WDG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule